// File: doc/BRIEF.md
# ECC-Checked Read Gearbox Buffer

This block sits on the read side of one lane of a memory controller and handles half of a 128-byte cache line, 64 bytes. Memory delivers that half in two strobed beats. Each beat carries four 64-bit words and one 8-bit check byte per word. Every word is decoded with a single-error-correct, double-error-detect code as it arrives, and the corrected result is written into an eight-word line buffer.

Only when both memory beats are stored does the block present the line on a 128-bit system-bus stream. The stream uses valid/ready and carries four beats, starting at the lowest address. Back-pressure rules: `out_valid` stays high and `out_data` stays unchanged while `out_ready` is low. A beat retires only on a cycle where `out_valid` and `out_ready` are both high. While the buffer holds an undelivered line, `mem_busy` is high and memory strobes are dropped.

Correctable errors set a sticky flag that only reset clears. An uncorrectable error anywhere in the line is reported on the final output beat, and the data is still delivered.

Top module: `ecc_read_gearbox`

## Requirements
- R1: After synchronous reset, `out_valid`, `mem_busy`, `out_ue`, `out_last` and `ce_flag` are all 0.
- R2: Memory beat 0 fills words 0..3 and beat 1 fills words 4..7. Word w of a beat is on `mem_data[64w+63:64w]`. `out_valid` stays 0 after the first beat and rises in the cycle after the clock edge that accepts the second beat. Idle cycles between the two beats are allowed.
- R3: Output beat k carries word 2k on `out_data[63:0]` and word 2k+1 on `out_data[127:64]`, for k = 0, 1, 2, 3 in that order. `out_last` is 1 only on beat 3.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values. A beat advances only on a clock edge where both are 1.
- R5: `mem_busy` is 1 from the cycle after the second beat is accepted until the edge that accepts the last output beat. After that edge, `mem_busy` and `out_valid` are both 0. A `mem_vld` strobe while `mem_busy` is 1 is ignored and changes neither the line being delivered nor the next line.
- R6: Check byte w is `mem_chk[8w+7:8w]`. Data bit i sits at the i-th code position in 3..71 that is not a power of two. Bits 6:0 of the check byte equal the XOR of the positions of all set data bits. Bit 7 makes the 64 data bits plus bits 6:0 even parity.
- R7: A single flipped bit in a word (data bit, Hamming bit or parity bit) is delivered as the original data and sets `ce_flag` from the next cycle.
- R8: Two flipped bits in any word of the line assert `out_ue` together with the final beat only. The received data is delivered unmodified.
- R9: `ce_flag` stays 1 until reset. The uncorrectable indication belongs to one line only: a following clean line delivers with `out_ue` at 0.
- R10: Reset asserted during delivery drops `out_valid`, `mem_busy` and `ce_flag`, and the next line is processed from its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_vld | input | 1 | Memory beat strobe |
| mem_data | input | 256 | Four 64-bit words of one memory beat |
| mem_chk | input | 32 | One check byte per word |
| mem_busy | output | 1 | Line buffer occupied, strobes refused |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 128 | Two corrected words, lower address in the low half |
| out_last | output | 1 | Final beat of the line |
| out_ue | output | 1 | Uncorrectable error in the line, with final beat |
| ce_flag | output | 1 | Sticky correctable-error flag |

## Verification
Several properties are checked on every cycle:
- the stream holds its beat under back-pressure;
- `out_ue` never appears outside the last beat;
- the correctable flag never falls without reset;
- the buffer frees itself right after the final handshake;
- a word decoder never reports correctable and uncorrectable together.

The scenarios are needed for the rest:
- that the right corrected words reach the right beat in the right order;
- that each error type is classified and fixed correctly;
- that strobes during busy are dropped;
- that a reset mid-line leaves nothing behind.

// File: rtl/ecc_gbx_pkg.sv
`timescale 1ns/1ps
package ecc_gbx_pkg;
  localparam int WORD_W = 64;
  localparam int CHK_W  = 8;
  localparam int HAM_W  = 7;
  localparam int MAX_POS = 71;

  typedef enum logic {PH_FILL = 1'b0, PH_SEND = 1'b1} phase_t;

  // XOR of the code positions of all set data bits
  function automatic logic [HAM_W-1:0] ham_bits(input logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] acc;
    int pos;
    acc = '0;
    pos = 3;
    for (int i = 0; i < WORD_W; i++) begin
      if ((pos & (pos - 1)) == 0) pos++;
      if (d[i]) acc = acc ^ HAM_W'(pos);
      pos++;
    end
    return acc;
  endfunction

  // Flip the data bit living at code position syn (if it is a data position)
  function automatic logic [WORD_W-1:0] flip_at(input logic [WORD_W-1:0] d,
                                                input logic [HAM_W-1:0] syn);
    logic [WORD_W-1:0] r;
    int pos;
    r = d;
    pos = 3;
    for (int i = 0; i < WORD_W; i++) begin
      if ((pos & (pos - 1)) == 0) pos++;
      if (HAM_W'(pos) == syn) r[i] = ~d[i];
      pos++;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_gbx_word_dec.sv
`timescale 1ns/1ps
module ecc_gbx_word_dec
  import ecc_gbx_pkg::*;
(
  input  logic [WORD_W-1:0] raw_d,
  input  logic [CHK_W-1:0]  raw_c,
  output logic [WORD_W-1:0] fix_d,
  output logic              err_ce,
  output logic              err_ue
);
  logic [HAM_W-1:0] syn;
  logic             par_odd;

  assign syn     = ham_bits(raw_d) ^ raw_c[HAM_W-1:0];
  assign par_odd = (^raw_d) ^ (^raw_c);

  always_comb begin
    fix_d  = raw_d;
    err_ce = 1'b0;
    err_ue = 1'b0;
    if (par_odd) begin
      if (syn > HAM_W'(MAX_POS)) begin
        err_ue = 1'b1;
      end else begin
        err_ce = 1'b1;
        fix_d  = flip_at(raw_d, syn);
      end
    end else if (syn != '0) begin
      err_ue = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_gbx_beat_seq.sv
`timescale 1ns/1ps
module ecc_gbx_beat_seq
  import ecc_gbx_pkg::*;
#(
  parameter int MEM_BEATS = 2,
  parameter int OUT_BEATS = 4,
  localparam int FILL_W = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
  localparam int BEAT_W = (OUT_BEATS > 1) ? $clog2(OUT_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_vld,
  input  logic              out_ready,
  output logic              wr_en,
  output logic [FILL_W-1:0] wr_slot,
  output logic              busy,
  output logic              out_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              out_last
);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(MEM_BEATS - 1);
  localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(OUT_BEATS - 1);

  phase_t            phase_q;
  logic [FILL_W-1:0] fill_q;
  logic [BEAT_W-1:0] beat_q;

  assign busy      = (phase_q == PH_SEND);
  assign out_valid = busy;
  assign wr_en     = mem_vld && !busy;
  assign wr_slot   = fill_q;
  assign beat_idx  = beat_q;
  assign out_last  = busy && (beat_q == BEAT_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FILL;
      fill_q  <= '0;
      beat_q  <= '0;
    end else if (phase_q == PH_FILL) begin
      if (mem_vld) begin
        if (fill_q == FILL_END) begin
          fill_q  <= '0;
          beat_q  <= '0;
          phase_q <= PH_SEND;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end else if (out_ready) begin
      if (beat_q == BEAT_END) begin
        phase_q <= PH_FILL;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(beat_idx));

  // R5
  busy_fill_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy && mem_vld |=> $stable(fill_q));

  // R3
  send_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> beat_idx == '0);
endmodule

// File: rtl/ecc_gbx_line_buf.sv
`timescale 1ns/1ps
module ecc_gbx_line_buf
  import ecc_gbx_pkg::*;
#(
  parameter int MEM_WORDS = 4,
  parameter int MEM_BEATS = 2,
  parameter int BUS_WORDS = 2,
  localparam int LINE_WORDS = MEM_WORDS * MEM_BEATS,
  localparam int OUT_BEATS  = LINE_WORDS / BUS_WORDS,
  localparam int FILL_W = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
  localparam int BEAT_W = (OUT_BEATS > 1) ? $clog2(OUT_BEATS) : 1,
  localparam int IDX_W  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [FILL_W-1:0]             wr_slot,
  input  logic [MEM_WORDS*WORD_W-1:0]   fix_d,
  input  logic [MEM_WORDS-1:0]          word_ce,
  input  logic [MEM_WORDS-1:0]          word_ue,
  input  logic [BEAT_W-1:0]             beat_idx,
  output logic [BUS_WORDS*WORD_W-1:0]   beat_data,
  output logic                          line_ue,
  output logic                          ce_sticky
);
  logic [WORD_W-1:0] words_q [LINE_WORDS];
  logic              first_slot;

  assign first_slot = (wr_slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LINE_WORDS; k++) words_q[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < LINE_WORDS; k++) begin
        if (wr_slot == FILL_W'(k / MEM_WORDS))
          words_q[k] <= fix_d[(k % MEM_WORDS)*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_ue   <= 1'b0;
      ce_sticky <= 1'b0;
    end else if (wr_en) begin
      line_ue   <= (first_slot ? 1'b0 : line_ue) | (|word_ue);
      ce_sticky <= ce_sticky | (|word_ce);
    end
  end

  always_comb begin
    for (int b = 0; b < BUS_WORDS; b++)
      beat_data[b*WORD_W +: WORD_W] =
        words_q[IDX_W'(int'(beat_idx) * BUS_WORDS + b)];
  end

  // R9
  ce_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ce_sticky |=> ce_sticky);
endmodule

// File: rtl/ecc_read_gearbox.sv
`timescale 1ns/1ps
module ecc_read_gearbox
  import ecc_gbx_pkg::*;
#(
  parameter int MEM_WORDS = 4,
  parameter int MEM_BEATS = 2,
  parameter int BUS_WORDS = 2,
  localparam int MEM_DW = MEM_WORDS * WORD_W,
  localparam int MEM_CW = MEM_WORDS * CHK_W,
  localparam int BUS_DW = BUS_WORDS * WORD_W,
  localparam int OUT_BEATS = (MEM_WORDS * MEM_BEATS) / BUS_WORDS,
  localparam int FILL_W = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
  localparam int BEAT_W = (OUT_BEATS > 1) ? $clog2(OUT_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_vld,
  input  logic [MEM_DW-1:0] mem_data,
  input  logic [MEM_CW-1:0] mem_chk,
  output logic              mem_busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_DW-1:0] out_data,
  output logic              out_last,
  output logic              out_ue,
  output logic              ce_flag
);
  logic [MEM_DW-1:0]    fix_d;
  logic [MEM_WORDS-1:0] word_ce;
  logic [MEM_WORDS-1:0] word_ue;
  logic                 wr_en;
  logic [FILL_W-1:0]    wr_slot;
  logic [BEAT_W-1:0]    beat_idx;
  logic                 line_ue;

  for (genvar w = 0; w < MEM_WORDS; w++) begin : g_dec
    ecc_gbx_word_dec u_dec (
      .raw_d  (mem_data[w*WORD_W +: WORD_W]),
      .raw_c  (mem_chk[w*CHK_W +: CHK_W]),
      .fix_d  (fix_d[w*WORD_W +: WORD_W]),
      .err_ce (word_ce[w]),
      .err_ue (word_ue[w])
    );
  end

  ecc_gbx_beat_seq #(
    .MEM_BEATS (MEM_BEATS),
    .OUT_BEATS (OUT_BEATS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_vld   (mem_vld),
    .out_ready (out_ready),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .busy      (mem_busy),
    .out_valid (out_valid),
    .beat_idx  (beat_idx),
    .out_last  (out_last)
  );

  ecc_gbx_line_buf #(
    .MEM_WORDS (MEM_WORDS),
    .MEM_BEATS (MEM_BEATS),
    .BUS_WORDS (BUS_WORDS)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .fix_d     (fix_d),
    .word_ce   (word_ce),
    .word_ue   (word_ue),
    .beat_idx  (beat_idx),
    .beat_data (out_data),
    .line_ue   (line_ue),
    .ce_sticky (ce_flag)
  );

  assign out_ue = line_ue && out_last;

  // R8
  ue_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_ue |-> out_last && out_valid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    out_last && out_ready |=> !out_valid && !mem_busy);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (word_ce & word_ue) == '0);
endmodule

// File: tb/ecc_read_gearbox_test.sv
`timescale 1ns/1ps
module ecc_read_gearbox_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mem_vld = 1'b0;
  logic [255:0] mem_data = '0;
  logic [31:0]  mem_chk = '0;
  logic         mem_busy;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic         out_last;
  logic         out_ue;
  logic         ce_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit ce_exp = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_read_gearbox uut (
    .clk(clk), .rst(rst), .mem_vld(mem_vld), .mem_data(mem_data),
    .mem_chk(mem_chk), .mem_busy(mem_busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_ue(out_ue), .ce_flag(ce_flag)
  );

  // seed[39:24] word[23:20] bitA[19:12] bitB[11:4] stall[3:0]; 8'hFF = no flip
  localparam logic [39:0] VECS [7] = '{
    {16'h1234, 4'd0, 8'hFF, 8'hFF, 4'd0},
    {16'hBEEF, 4'd0, 8'hFF, 8'hFF, 4'd2},
    {16'h0F0F, 4'd3, 8'd17, 8'hFF, 4'd1},
    {16'hA5A5, 4'd6, 8'd66, 8'hFF, 4'd0},
    {16'h5555, 4'd5, 8'd2,  8'd40, 4'd1},
    {16'hCAFE, 4'd0, 8'hFF, 8'hFF, 4'd0},
    {16'h7777, 4'd7, 8'd71, 8'hFF, 4'd0}
  };

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Encoder of the R6 layout, built from an explicit 72-bit codeword
  function automatic logic [7:0] tb_code(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  c;
    int k;
    cw = '0;
    k = 0;
    for (int p = 3; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int j = 0; j < 7; j++)
      for (int p = 1; p <= 71; p++)
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [63:0] mk_word(input logic [15:0] s, input int j);
    return {s ^ 16'(j * 4369), 16'(s * 3 + j), ~s, 16'(j) ^ 16'h5A00};
  endfunction

  task automatic send_beat(input logic [255:0] d, input logic [31:0] c);
    mem_data = d;
    mem_chk  = c;
    mem_vld  = 1'b1;
    @(negedge clk);
    mem_vld  = 1'b0;
  endtask

  task automatic run_line(input logic [39:0] v, input bit gap, input bit junk);
    logic [63:0] orig [8];
    logic [63:0] rx [8];
    logic [7:0]  cb [8];
    logic [63:0] expw [8];
    logic [255:0] bd [2];
    logic [31:0]  bc [2];
    int nflip;
    int w;
    int fa;
    int fb;
    int stall;
    w = int'(v[23:20]);
    fa = int'(v[19:12]);
    fb = int'(v[11:4]);
    stall = int'(v[3:0]);
    nflip = 0;
    for (int j = 0; j < 8; j++) begin
      orig[j] = mk_word(v[39:24], j);
      rx[j] = orig[j];
      cb[j] = tb_code(orig[j]);
    end
    if (fa != 255) begin
      nflip++;
      if (fa < 64) rx[w][fa] = ~rx[w][fa]; else cb[w][fa-64] = ~cb[w][fa-64];
    end
    if (fb != 255) begin
      nflip++;
      if (fb < 64) rx[w][fb] = ~rx[w][fb]; else cb[w][fb-64] = ~cb[w][fb-64];
    end
    for (int j = 0; j < 8; j++) expw[j] = (nflip == 2) ? rx[j] : orig[j];
    if (nflip == 1) ce_exp = 1'b1;
    for (int m = 0; m < 2; m++) begin
      bd[m] = {rx[4*m+3], rx[4*m+2], rx[4*m+1], rx[4*m]};
      bc[m] = {cb[4*m+3], cb[4*m+2], cb[4*m+1], cb[4*m]};
    end
    send_beat(bd[0], bc[0]);
    check(out_valid == 1'b0, "R2 valid after one beat", 128'(out_valid), 128'd0);
    if (gap) @(negedge clk);
    send_beat(bd[1], bc[1]);
    check(out_valid == 1'b1 && mem_busy == 1'b1, "R5 busy/valid after fill",
          128'({out_valid, mem_busy}), 128'd3);
    if (junk) begin
      send_beat(~bd[1], ~bc[1]);
      check(out_valid == 1'b1, "R5 valid after ignored strobe", 128'(out_valid), 128'd1);
    end
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < stall; s++) begin
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1 && out_data == {expw[2*k+1], expw[2*k]},
              "R4 hold under stall", out_data, {expw[2*k+1], expw[2*k]});
      end
      out_ready = 1'b1;
      check(out_data == {expw[2*k+1], expw[2*k]},
            (nflip == 1) ? "R7 corrected beat" : "R3 beat data",
            out_data, {expw[2*k+1], expw[2*k]});
      check(out_last == (k == 3), "R3 last flag", 128'(out_last), 128'(k == 3));
      check(out_ue == (k == 3 && nflip == 2), "R8 ue placement",
            128'(out_ue), 128'(k == 3 && nflip == 2));
      @(negedge clk);
      out_ready = 1'b0;
    end
    check(mem_busy == 1'b0 && out_valid == 1'b0, "R5 release after last",
          128'({mem_busy, out_valid}), 128'd0);
    check(ce_flag == ce_exp, "R9 sticky ce", 128'(ce_flag), 128'(ce_exp));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({out_valid, mem_busy, out_ue, out_last, ce_flag} == 5'b0, "R1 reset state",
          128'({out_valid, mem_busy, out_ue, out_last, ce_flag}), 128'd0);
    // R6 encoding used by every vector
    for (int v = 0; v < 7; v++) run_line(VECS[v], (v % 2) == 1, 1'b0);
    // R5 strobe while busy is dropped, next line starts clean at beat 0
    run_line(VECS[5], 1'b0, 1'b1);
    run_line(VECS[0], 1'b1, 1'b0);
    // R10 reset mid-delivery
    send_beat('1, '1);
    send_beat('0, '0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ce_exp = 1'b0;
    check({out_valid, mem_busy, ce_flag, out_ue} == 4'b0, "R10 reset mid-line",
          128'({out_valid, mem_busy, ce_flag, out_ue}), 128'd0);
    run_line(VECS[1], 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule